// File: doc/BRIEF.md
# Timer Input Capture Unit

This block stamps external events with the value of a free-running 16-bit timer. An event arrives either on a dedicated capture pin or as the output bit of an analog comparator, chosen by a source-select control bit. The chosen signal is synchronized, optionally debounced by a noise filter, and fed to an edge detector with selectable polarity. When a qualifying edge is seen, the timer value is copied into a 16-bit capture register and a capture flag is raised. The flag can raise an interrupt request. It is cleared by an interrupt acknowledge or by a write of one.

Software reaches the block through an 8-bit register bus with four addresses. A 16-bit capture value is read as two bytes. Reading the low byte parks the high byte in a shared temporary register, and a later high-byte read returns that parked copy, so the two halves always belong to the same capture.

The bus is a plain strobe interface with no back-pressure. A read strobe is always accepted, and its data is valid on `bus_rdata` in the cycle after the strobe, where it stays until the next read. A write strobe takes effect at the clock edge that samples it. No stream data passes through this block, so it has no valid/ready pair.

Top module: `icap_unit`

## Requirements
- R1: CTRL bit 0 selects the trigger source: 0 uses `cap_pin`, 1 uses `cmp_out`. Activity on the source that is not selected never causes a capture.
- R2: CTRL bit 1 selects the polarity: 1 captures on a rising edge, 0 captures on a falling edge. An edge of the other polarity never captures.
- R3: With the filter off, the input passes through two synchronizing flops. If the source changes just before clock edge k, the flag is still clear after edge k+1 and is set after edge k+2. A pulse only two cycles wide is still captured.
- R4: With CTRL bit 2 set, the filter passes a new level only after four consecutive equal samples. This adds four cycles: the flag is clear after edge k+5 and set after edge k+6. A three-cycle pulse is rejected.
- R5: On a capture, the full 16-bit timer value is written into the capture register, and the flag (STAT bit 0) is set at that same clock edge.
- R6: `irq` is high exactly when the flag is set and CTRL bit 3 (interrupt enable) is 1.
- R7: A one-cycle pulse on `int_ack` clears the flag.
- R8: Writing STAT with bit 0 = 1 clears the flag. Writing STAT with bit 0 = 0 leaves it unchanged.
- R9: If a capture and a clear land in the same cycle, the capture wins and the flag ends set.
- R10: Reading address 2 returns the low byte and loads the high byte into the temporary register. Reading address 3 returns the temporary register, even if a newer capture has happened since the low-byte read.
- R11: A capture that arrives while the flag is still set overwrites the capture register, and the flag stays set.
- R12: After reset, CTRL, STAT, the capture register, `bus_rdata` and `irq` are all zero.
- R13: Address 0 reads back CTRL bits 3:0 with bits 7:4 as zero, and writes ignore bits 7:4. Read data appears the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | External capture pin (asynchronous) |
| cmp_out | input | 1 | Analog comparator output bit (asynchronous) |
| tmr_count | input | 16 | Free-running timer value |
| bus_addr | input | 2 | Register address: 0 CTRL, 1 STAT, 2 capture low, 3 capture high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| int_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench times captures to the exact clock edge, with the filter off and with it on. A design with one synchronizer flop too many or too few, or with a filter window that is off by one, raises `irq` a cycle early or late and fails. Pulses of two and three cycles separate a design that filters when it should not from one that lets glitches through while filtering. An acknowledge placed in the very cycle of a capture catches a design that gives the clear priority. A capture slipped between the low-byte and high-byte reads catches a high byte taken live instead of from the temporary register. Writing zero to the flag bit, and toggling the source that is not selected, catch designs that clear the flag or capture where they should not.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_STAT  = 2'd1,
    A_CAPLO = 2'd2,
    A_CAPHI = 2'd3
  } reg_addr_e;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic ien;
    logic filt;
    logic pol;
    logic src;
  } ctrl_t;
endpackage

// File: rtl/icap_cond.sv
module icap_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic filt_en,
  output logic level
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic sample;
  logic filt_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end
  assign sample = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_LEN > 1) begin : g_filt
      logic [FILT_LEN-2:0] hist_q;
      logic [FILT_LEN-1:0] window;
      logic filt_q;

      assign window = {hist_q, sample};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= '0;
          filt_q <= 1'b0;
        end else begin
          hist_q <= window[FILT_LEN-2:0];
          if (&window)       filt_q <= 1'b1;
          else if (~|window) filt_q <= 1'b0;
        end
      end
      assign filt_lvl = filt_q;

      AST_FILT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(sample) == filt_q)); // R4
    end else begin : g_nofilt
      assign filt_lvl = sample;
    end
  endgenerate

  assign level = filt_en ? filt_lvl : sample;
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic pol,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign hit = pol ? (level & ~prev_q) : (~level & prev_q);

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!hit || !$stable(pol))); // R2
endmodule

// File: rtl/icap_regs.sv
module icap_regs
  import icap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_stb,
  input  logic [CNT_W-1:0] count,
  input  logic             int_ack,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output ctrl_t            ctrl,
  output logic             flag
);
  localparam int HI_W = CNT_W - BUS_W;

  reg_addr_e        addr;
  ctrl_t            ctrl_q;
  logic             flag_q;
  logic [CNT_W-1:0] cap_q;
  logic [HI_W-1:0]  temp_q;
  logic [BUS_W-1:0] rdata_q;
  logic             stat_w1;
  logic             unused_wbits;

  assign addr         = reg_addr_e'(bus_addr);
  assign stat_w1      = bus_wr && (addr == A_STAT) && bus_wdata[0];
  assign unused_wbits = ^bus_wdata[BUS_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (bus_wr && addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else if (cap_stb) begin
      flag_q <= 1'b1;
      cap_q  <= count;
    end else if (int_ack || stat_w1) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      temp_q  <= '0;
    end else if (bus_rd) begin
      unique case (addr)
        A_CTRL:  rdata_q <= {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
        A_STAT:  rdata_q <= {{(BUS_W-1){1'b0}}, flag_q};
        A_CAPLO: begin
          rdata_q <= cap_q[BUS_W-1:0];
          temp_q  <= cap_q[CNT_W-1:BUS_W];
        end
        A_CAPHI: rdata_q <= {{(BUS_W-HI_W){1'b0}}, temp_q};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign ctrl      = ctrl_q;
  assign flag      = flag_q;

  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> flag_q); // R9
  AST_CAP_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (cap_q == $past(count))); // R5
  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(cap_q)); // R11
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !cap_stb) |=> !flag_q); // R7
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr == A_STAT && !bus_wdata[0] && flag_q && !int_ack) |=> flag_q); // R8
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic             cmp_out,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             int_ack,
  output logic             irq
);
  ctrl_t ctrl;
  logic  src_sig;
  logic  level;
  logic  hit;
  logic  flag;

  assign src_sig = ctrl.src ? cmp_out : cap_pin;

  icap_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst_n(rst_n), .din(src_sig), .filt_en(ctrl.filt), .level(level)
  );

  icap_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level(level), .pol(ctrl.pol), .hit(hit)
  );

  icap_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap_stb(hit), .count(tmr_count),
    .int_ack(int_ack), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl(ctrl), .flag(flag)
  );

  assign irq = flag & ctrl.ien;

  AST_IRQ_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $stable(ctrl.ien)) |-> $past(hit)); // R6
endmodule

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0;
  logic        cmp_out = 1'b0;
  logic [15:0] tmr_count = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        int_ack = 1'b0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icap_unit dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cmp_out(cmp_out),
    .tmr_count(tmr_count), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_ack(int_ack), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: one read result per strobe seen on the previous edge
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("R13 unexpected read", 16'(bus_rdata), 16'hFFFF);
      else check(tag_q.pop_front(), 16'(bus_rdata), 16'(exp_q.pop_front()));
    end
  end

  task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cmp(logic [15:0] cnt);
    tmr_count = cnt;
    @(negedge clk) cmp_out = 1'b1;
    wait_cyc(5);
    @(negedge clk) cmp_out = 1'b0;
    wait_cyc(5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    // R12 reset state
    check("R12 irq", 16'(irq), 16'h0);
    rd(2'd0, 8'h00, "R12 ctrl");
    rd(2'd1, 8'h00, "R12 stat");
    rd(2'd2, 8'h00, "R12 caplo");
    rd(2'd3, 8'h00, "R12 caphi");
    // R13 control readback
    wr(2'd0, 8'h0A);
    rd(2'd0, 8'h0A, "R13 ctrl");
    wr(2'd0, 8'hFA);
    rd(2'd0, 8'h0A, "R13 upper bits");
    // R3 latency without filter, rising edge
    tmr_count = 16'h1234;
    @(negedge clk) cap_pin = 1'b1;
    wait_cyc(2);
    check("R3 flag not yet", 16'(irq), 16'h0);
    wait_cyc(1);
    check("R3 flag at k+2", 16'(irq), 16'h1);
    rd(2'd1, 8'h01, "R5 stat");
    rd(2'd2, 8'h34, "R5 caplo");
    rd(2'd3, 8'h12, "R5 caphi");
    // R6 enable gate
    wr(2'd0, 8'h02);
    check("R6 ien off", 16'(irq), 16'h0);
    rd(2'd1, 8'h01, "R6 flag kept");
    wr(2'd0, 8'h0A);
    check("R6 ien on", 16'(irq), 16'h1);
    // R7 acknowledge
    @(negedge clk) int_ack = 1'b1;
    @(negedge clk) int_ack = 1'b0;
    check("R7 ack clears", 16'(irq), 16'h0);
    // R2 polarity
    tmr_count = 16'h00AB;
    @(negedge clk) cap_pin = 1'b0;
    wait_cyc(5);
    check("R2 fall ignored in rise mode", 16'(irq), 16'h0);
    wr(2'd0, 8'h08);
    @(negedge clk) cap_pin = 1'b1;
    wait_cyc(5);
    check("R2 rise ignored in fall mode", 16'(irq), 16'h0);
    @(negedge clk) cap_pin = 1'b0;
    wait_cyc(5);
    check("R2 fall captured", 16'(irq), 16'h1);
    rd(2'd2, 8'hAB, "R2 caplo");
    rd(2'd3, 8'h00, "R2 caphi");
    // R8 write-one-to-clear
    wr(2'd1, 8'h00);
    check("R8 write zero", 16'(irq), 16'h1);
    wr(2'd1, 8'hFE);
    check("R8 bit0 zero", 16'(irq), 16'h1);
    wr(2'd1, 8'h01);
    check("R8 write one", 16'(irq), 16'h0);
    // R1 source select
    pulse_cmp(16'h5A5A);
    check("R1 cmp ignored on pin source", 16'(irq), 16'h0);
    wr(2'd0, 8'h09);
    @(negedge clk) cap_pin = 1'b1;
    wait_cyc(5);
    @(negedge clk) cap_pin = 1'b0;
    wait_cyc(5);
    check("R1 pin ignored on cmp source", 16'(irq), 16'h0);
    pulse_cmp(16'h5A5A);
    check("R1 cmp captured", 16'(irq), 16'h1);
    rd(2'd2, 8'h5A, "R1 caplo");
    // R11 overwrite while flag set
    pulse_cmp(16'h0F0E);
    rd(2'd1, 8'h01, "R11 flag stays");
    rd(2'd2, 8'h0E, "R11 caplo");
    rd(2'd3, 8'h0F, "R11 caphi");
    // R10 coherent high byte
    pulse_cmp(16'h3344);
    rd(2'd2, 8'h44, "R10 caplo");
    pulse_cmp(16'h5566);
    rd(2'd3, 8'h33, "R10 temp held");
    rd(2'd2, 8'h66, "R10 new caplo");
    rd(2'd3, 8'h55, "R10 new caphi");
    // R9 capture beats ack in the same cycle
    tmr_count = 16'h7788;
    @(negedge clk) cmp_out = 1'b1;
    wait_cyc(5);
    @(negedge clk) cmp_out = 1'b0;
    wait_cyc(2);
    int_ack = 1'b1;
    @(negedge clk) int_ack = 1'b0;
    check("R9 set wins", 16'(irq), 16'h1);
    rd(2'd2, 8'h88, "R9 caplo");
    // R4 noise filter
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h0E);
    wait_cyc(6);
    tmr_count = 16'h9ABC;
    @(negedge clk) cap_pin = 1'b1;
    wait_cyc(3);
    cap_pin = 1'b0;
    wait_cyc(10);
    check("R4 short pulse rejected", 16'(irq), 16'h0);
    @(negedge clk) cap_pin = 1'b1;
    wait_cyc(6);
    check("R4 not yet at k+5", 16'(irq), 16'h0);
    wait_cyc(1);
    check("R4 captured at k+6", 16'(irq), 16'h1);
    rd(2'd2, 8'hBC, "R4 caplo");
    // R3 short pulse passes without filter
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h0A);
    @(negedge clk) cap_pin = 1'b0;
    wait_cyc(6);
    tmr_count = 16'h0DEF;
    @(negedge clk) cap_pin = 1'b1;
    wait_cyc(2);
    cap_pin = 1'b0;
    wait_cyc(5);
    check("R3 two-cycle pulse captured", 16'(irq), 16'h1);
    rd(2'd2, 8'hEF, "R3 caplo");
    rd(2'd3, 8'h0D, "R3 caphi");
    wait_cyc(3);
    check("R13 all reads answered", 16'(exp_q.size()), 16'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule